// File: doc/BRIEF.md
# Programmable SRAM Strobe Timing Sequencer

This block turns a single access request from an internal master into the chip select, address, read strobe, write strobe and data-bus timing that an asynchronous SRAM-style device expects. Seven address areas (0 to 6) each own a four-bit field in one 32-bit timing register. The field sets:

- how many cycles the address leads the strobe,
- how many cycles are added after the strobe or the read sample point,
- for two of the areas, whether the read strobe is released at the sample point.

A per-area type input says whether an area is plain SRAM, byte-control SRAM, or something else. Areas of any other type run with no setup and no hold.

An access is taken only while the sequencer is idle. It then walks these states:

- ST_IDLE
- ST_ADDR_SETUP, taken only when setup is programmed
- ST_STROBE, lasting the strobe-wait input plus one cycle
- ST_HOLD, taken only when hold is non-zero
- ST_DONE, which pulses `rsp_done` for one cycle and returns to ST_IDLE

The transitions are:

- **Accept:** ST_IDLE to ST_ADDR_SETUP or to ST_STROBE.
- **Setup end:** ST_ADDR_SETUP to ST_STROBE.
- **Sample:** ST_STROBE to ST_HOLD or to ST_DONE.
- **Hold end:** ST_HOLD to ST_DONE.
- **Finish:** ST_DONE to ST_IDLE.

Read data is captured at the clock edge that ends the last strobe cycle and is presented on `rsp_rdata`.

Top module: `sram_strobe_seq`

## Requirements
- R1: After reset the sequencer is idle with `req_ready`=1, `bus_cs_n`, `bus_rd_n` and `bus_we_n` all 1, `bus_dq_oe`=0, `rsp_done`=0, and `cfg_rdata` equal to zero.
- R2: The timing register holds, for area n (0..6), hold in bits 4n+1..4n, setup in bit 4n+2, and early read release in bit 4n+3. Bit 4n+3 exists only for areas 1 and 4. All other bit-3 positions and bits 31..28 read as zero, and writes to them are ignored.
- R3: Let s be the area's setup bit. `bus_cs_n` is low for exactly s cycles before the first strobe cycle of an access.
- R4: Let w be the `strobe_wait` value sampled at acceptance. The active strobe (`bus_rd_n` on a read, `bus_we_n` on a write) lasts at least w+1 cycles, and the write strobe lasts exactly w+1 cycles.
- R5: Let h be the area's two-bit hold value. After the write strobe rises, `bus_cs_n`, `bus_addr` and the driven write data stay valid for exactly h more cycles.
- R6: Read data is the value on `bus_dq_in` during the last strobe cycle (cycle s+w after acceptance). It is returned on `rsp_rdata` and is held there until the next read completes.
- R7: On a read with early release off, the hold cycles follow the sample point with the read strobe still low. The read strobe is then low for w+1+h cycles.
- R8: For areas 1 and 4 configured as SRAM with the early-release bit set, the read strobe is low only w+1 cycles. Chip select still covers the h hold cycles.
- R9: For an area configured as byte-control SRAM, the early-release bit is treated as 0.
- R10: Area type is selected by `area_sram[n]`=1 for SRAM and `area_bytectl[n]`=1 for byte-control SRAM, with byte-control winning if both are set. An area of neither type, and the unused area number 7, uses zero setup and zero hold.
- R11: `rsp_done` is a one-cycle pulse in cycle s+w+1+h after acceptance. `req_ready` is 1 only while idle, and a request presented while busy is ignored.
- R12: `bus_dq_oe` is 1 for the whole chip-select window of a write and is never 1 during a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the timing register |
| cfg_wdata | input | 32 | Timing register write value |
| cfg_rdata | output | 32 | Timing register read value |
| area_sram | input | 7 | Per-area SRAM type flag |
| area_bytectl | input | 7 | Per-area byte-control SRAM type flag |
| strobe_wait | input | 4 | Strobe wait count; the strobe lasts this value plus one cycle |
| req_valid | input | 1 | Access request |
| req_ready | output | 1 | Sequencer idle, so a request is accepted |
| req_area | input | 3 | Area number of the request |
| req_addr | input | 20 | Access address |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_wdata | input | 16 | Write data |
| req_be | input | 2 | Byte enables, active high |
| bus_addr | output | 20 | External address |
| bus_cs_n | output | 1 | Chip select, active low |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_we_n | output | 1 | Write strobe, active low |
| bus_be_n | output | 2 | Byte enables, active low |
| bus_dq_out | output | 16 | Write data out |
| bus_dq_oe | output | 1 | Data bus drive enable |
| bus_dq_in | input | 16 | Read data in |
| rsp_rdata | output | 16 | Captured read data |
| rsp_done | output | 1 | One-cycle completion pulse |

## Verification
The accepting edge is taken as cycle 0, and every expected position is counted from it:

- chip select first falls in cycle 0;
- the strobe starts in cycle s;
- the read sample is the value on `bus_dq_in` in cycle s+w;
- `rsp_done` rises in cycle s+w+1+h.

The bench drives `bus_dq_in` with a value that changes every cycle. That makes the captured word name the exact cycle it was sampled in. Outputs are sampled on the falling edge, half a period after the registers settle. Each access is then reduced to cycle counts (lead-in, strobe width, post-strobe hold, done position), and these are compared with values the bench computes from the programmed fields.

// File: rtl/sss_pkg.sv
package sss_pkg;

    localparam int NUM_AREAS = 7;
    localparam int FIELD_W   = 4;
    localparam int REG_W     = 32;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR_SETUP,
        ST_STROBE,
        ST_HOLD,
        ST_DONE
    } seq_state_e;

    typedef struct packed {
        logic       setup;
        logic [1:0] hold;
        logic       early;
    } area_timing_t;

endpackage

// File: rtl/sss_wait_reg.sv
module sss_wait_reg
    import sss_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [REG_W-1:0] wdata,
    output logic [REG_W-1:0] value
);

    localparam int SLOTS = REG_W / FIELD_W;

    logic [REG_W-1:0] keep;
    logic [REG_W-1:0] reg_q;

    // Build the mask of implemented bits, one field at a time.
    for (genvar n = 0; n < SLOTS; n++) begin : g_mask
        assign keep[FIELD_W*n +: 3] = (n < NUM_AREAS) ? 3'b111 : 3'b000;
        assign keep[FIELD_W*n + 3]  = (n == 1) || (n == 4);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  reg_q <= '0;
        else if (we) reg_q <= wdata & keep;
    end

    assign value = reg_q;

    // R2: unimplemented bits never become set in the stored register
    a_r2_unused_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_q & ~keep) == '0);

endmodule

// File: rtl/sss_timing_sel.sv
module sss_timing_sel
    import sss_pkg::*;
#(
    parameter int AREA_W = 3
) (
    input  logic [REG_W-1:0]     wait_reg,
    input  logic [AREA_W-1:0]    area,
    input  logic [NUM_AREAS-1:0] area_sram,
    input  logic [NUM_AREAS-1:0] area_bytectl,
    output area_timing_t         timing
);

    logic [FIELD_W-1:0] nib;
    logic               is_sram;
    logic               is_bctl;

    always_comb begin
        nib     = '0;
        is_sram = 1'b0;
        is_bctl = 1'b0;
        if (int'(area) < NUM_AREAS) begin
            nib     = wait_reg[FIELD_W*int'(area) +: FIELD_W];
            is_bctl = area_bytectl[area];
            is_sram = area_sram[area] && !area_bytectl[area];
        end
        timing.setup = (is_sram || is_bctl) && nib[2];
        timing.hold  = (is_sram || is_bctl) ? nib[1:0] : 2'b00;
        timing.early = is_sram && nib[3];
    end

endmodule

// File: rtl/sss_fsm.sv
module sss_fsm
    import sss_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int WAIT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  area_timing_t      timing,
    input  logic [WAIT_W-1:0] strobe_wait,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic [BE_W-1:0]   req_be,
    output logic [ADDR_W-1:0] bus_addr,
    output logic              bus_cs_n,
    output logic              bus_rd_n,
    output logic              bus_we_n,
    output logic [BE_W-1:0]   bus_be_n,
    output logic [DATA_W-1:0] bus_dq_out,
    output logic              bus_dq_oe,
    input  logic [DATA_W-1:0] bus_dq_in,
    output logic [DATA_W-1:0] rsp_rdata,
    output logic              rsp_done
);

    localparam int CNT_W = (WAIT_W > 2) ? WAIT_W : 2;

    seq_state_e        state_q, state_d;
    logic [CNT_W-1:0]  cnt_q, cnt_d;
    area_timing_t      tim_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic [BE_W-1:0]   be_q;
    logic              write_q;
    logic              accept;
    logic              sample;
    logic              active;

    assign accept = (state_q == ST_IDLE) && req_valid;
    assign sample = (state_q == ST_STROBE) && (cnt_q == '0);

    // Next-state and counter logic
    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        unique case (state_q)
            ST_IDLE: begin
                if (req_valid) begin
                    state_d = timing.setup ? ST_ADDR_SETUP : ST_STROBE;
                    cnt_d   = CNT_W'(strobe_wait);
                end
            end
            ST_ADDR_SETUP: state_d = ST_STROBE;
            ST_STROBE: begin
                if (cnt_q == '0) begin
                    if (tim_q.hold != 2'b00) begin
                        state_d = ST_HOLD;
                        cnt_d   = CNT_W'(tim_q.hold) - CNT_W'(1);
                    end else begin
                        state_d = ST_DONE;
                    end
                end else begin
                    cnt_d = cnt_q - CNT_W'(1);
                end
            end
            ST_HOLD: begin
                if (cnt_q == '0) state_d = ST_DONE;
                else             cnt_d   = cnt_q - CNT_W'(1);
            end
            ST_DONE: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and captured request fields
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            tim_q   <= '0;
            addr_q  <= '0;
            wdata_q <= '0;
            be_q    <= '0;
            write_q <= 1'b0;
            rdata_q <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (accept) begin
                tim_q   <= timing;
                addr_q  <= req_addr;
                wdata_q <= req_wdata;
                be_q    <= req_be;
                write_q <= req_write;
            end
            if (sample && !write_q) rdata_q <= bus_dq_in;
        end
    end

    // Output decode
    always_comb begin
        active    = 1'b0;
        bus_rd_n  = 1'b1;
        bus_we_n  = 1'b1;
        req_ready = 1'b0;
        rsp_done  = 1'b0;
        unique case (state_q)
            ST_IDLE:       req_ready = 1'b1;
            ST_ADDR_SETUP: active = 1'b1;
            ST_STROBE: begin
                active   = 1'b1;
                bus_rd_n = write_q;
                bus_we_n = !write_q;
            end
            ST_HOLD: begin
                active   = 1'b1;
                bus_rd_n = write_q || tim_q.early;
            end
            ST_DONE:       rsp_done = 1'b1;
            default:       req_ready = 1'b0;
        endcase
    end

    assign bus_cs_n   = !active;
    assign bus_dq_oe  = active && write_q;
    assign bus_be_n   = active ? ~be_q : '1;
    assign bus_addr   = addr_q;
    assign bus_dq_out = wdata_q;
    assign rsp_rdata  = rdata_q;

    // R3: a strobe is only ever asserted inside the chip-select window
    a_r3_strobe_in_cs: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_rd_n || !bus_we_n) |-> !bus_cs_n);
    // R5: address stays put while chip select stays low
    a_r5_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_cs_n && $past(!bus_cs_n)) |-> $stable(bus_addr));
    // R11: done lasts one cycle and follows the end of the chip-select window
    a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_done |=> !rsp_done);
    a_r11_done_after_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rsp_done) |-> $past(!bus_cs_n));
    // R12: data never driven while the read strobe is low
    a_r12_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_rd_n |-> !bus_dq_oe);

endmodule

// File: rtl/sram_strobe_seq.sv
module sram_strobe_seq
    import sss_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 16,
    parameter int BE_W   = 2,
    parameter int WAIT_W = 4,
    parameter int AREA_W = 3
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [31:0]          cfg_wdata,
    output logic [31:0]          cfg_rdata,
    input  logic [6:0]           area_sram,
    input  logic [6:0]           area_bytectl,
    input  logic [WAIT_W-1:0]    strobe_wait,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [AREA_W-1:0]    req_area,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic                 req_write,
    input  logic [DATA_W-1:0]    req_wdata,
    input  logic [BE_W-1:0]      req_be,
    output logic [ADDR_W-1:0]    bus_addr,
    output logic                 bus_cs_n,
    output logic                 bus_rd_n,
    output logic                 bus_we_n,
    output logic [BE_W-1:0]      bus_be_n,
    output logic [DATA_W-1:0]    bus_dq_out,
    output logic                 bus_dq_oe,
    input  logic [DATA_W-1:0]    bus_dq_in,
    output logic [DATA_W-1:0]    rsp_rdata,
    output logic                 rsp_done
);

    logic [REG_W-1:0] wait_val;
    area_timing_t     timing;

    sss_wait_reg i_wait_reg (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (cfg_we),
        .wdata (cfg_wdata),
        .value (wait_val)
    );

    assign cfg_rdata = wait_val;

    sss_timing_sel #(.AREA_W(AREA_W)) i_timing_sel (
        .wait_reg     (wait_val),
        .area         (req_area),
        .area_sram    (area_sram),
        .area_bytectl (area_bytectl),
        .timing       (timing)
    );

    sss_fsm #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W),
        .BE_W   (BE_W),
        .WAIT_W (WAIT_W)
    ) i_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .timing      (timing),
        .strobe_wait (strobe_wait),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_addr    (req_addr),
        .req_write   (req_write),
        .req_wdata   (req_wdata),
        .req_be      (req_be),
        .bus_addr    (bus_addr),
        .bus_cs_n    (bus_cs_n),
        .bus_rd_n    (bus_rd_n),
        .bus_we_n    (bus_we_n),
        .bus_be_n    (bus_be_n),
        .bus_dq_out  (bus_dq_out),
        .bus_dq_oe   (bus_dq_oe),
        .bus_dq_in   (bus_dq_in),
        .rsp_rdata   (rsp_rdata),
        .rsp_done    (rsp_done)
    );

endmodule

// File: tb/test_sram_strobe_seq.sv
module test_sram_strobe_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic [31:0] cfg_rdata;
    logic [6:0]  area_sram = '0;
    logic [6:0]  area_bytectl = '0;
    logic [3:0]  strobe_wait = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [2:0]  req_area = '0;
    logic [19:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [15:0] req_wdata = '0;
    logic [1:0]  req_be = '0;
    logic [19:0] bus_addr;
    logic        bus_cs_n, bus_rd_n, bus_we_n, bus_dq_oe, rsp_done;
    logic [1:0]  bus_be_n;
    logic [15:0] bus_dq_out;
    logic [15:0] bus_dq_in = '0;
    logic [15:0] rsp_rdata;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2 clk = ~clk;

    sram_strobe_seq i_sram_strobe_seq (
        .clk, .rst_n, .cfg_we, .cfg_wdata, .cfg_rdata, .area_sram, .area_bytectl,
        .strobe_wait, .req_valid, .req_ready, .req_area, .req_addr, .req_write,
        .req_wdata, .req_be, .bus_addr, .bus_cs_n, .bus_rd_n, .bus_we_n, .bus_be_n,
        .bus_dq_out, .bus_dq_oe, .bus_dq_in, .rsp_rdata, .rsp_done
    );

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct packed {
        logic [2:0]  area;
        logic [1:0]  kind;   // 0 other, 1 SRAM, 2 byte-control
        logic        wr;
        logic [3:0]  wt;
        logic [31:0] cfg;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{3'd0, 2'd1, 1'b0, 4'd1, 32'h0000_0000},
        '{3'd0, 2'd1, 1'b1, 4'd2, 32'h0000_0007},
        '{3'd1, 2'd1, 1'b0, 4'd0, 32'h0000_00E0},
        '{3'd1, 2'd1, 1'b0, 4'd3, 32'h0000_0060},
        '{3'd4, 2'd2, 1'b0, 4'd1, 32'h000F_0000},
        '{3'd4, 2'd1, 1'b0, 4'd2, 32'h000F_0000},
        '{3'd2, 2'd0, 1'b1, 4'd1, 32'hFFFF_FFFF},
        '{3'd6, 2'd1, 1'b1, 4'd0, 32'h0700_0000},
        '{3'd3, 2'd2, 1'b1, 4'd4, 32'h0000_D000},
        '{3'd5, 2'd1, 1'b0, 4'd5, 32'h0090_0000}
    };

    task automatic chk(input int act, input int exp, input string what);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", what, act, exp);
        end
    endtask

    task automatic write_cfg(input logic [31:0] v);
        @(negedge clk);
        cfg_we = 1'b1; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Runs one access and checks every timing result against the requirements.
    task automatic run_access(input logic [2:0] area, input logic [1:0] kind,
                              input logic wr, input logic [3:0] wt,
                              input logic [31:0] cfg, input string tag);
        logic [3:0] nib;
        int s, h, e, w;
        int lead, cs_cnt, rd_cnt, we_cnt, oe_cnt, post, done_at, done_cnt, addr_bad;
        bit seen_strobe, we_done;
        logic [19:0] a;
        nib = (area < 7) ? cfg[4*area +: 4] : 4'h0;
        w = wt;
        if (kind == 2'd0 || area == 3'd7) begin s = 0; h = 0; e = 0; end
        else begin
            s = nib[2]; h = nib[1:0];
            e = (kind == 2'd1 && (area == 3'd1 || area == 3'd4)) ? nib[3] : 0;
        end
        a = 20'h5_0000 + 20'(area) * 20'h111 + 20'(w);
        write_cfg(cfg);
        @(negedge clk);
        area_sram    = (kind == 2'd1 && area < 7) ? 7'(1 << area) : 7'h0;
        area_bytectl = (kind == 2'd2 && area < 7) ? 7'(1 << area) : 7'h0;
        strobe_wait = wt; req_area = area; req_addr = a; req_write = wr;
        req_wdata = 16'hC3A0 + 16'(w); req_be = 2'b10; req_valid = 1'b1;
        bus_dq_in = 16'hBEEF;
        lead = 0; cs_cnt = 0; rd_cnt = 0; we_cnt = 0; oe_cnt = 0; post = 0;
        done_at = -1; done_cnt = 0; addr_bad = 0; seen_strobe = 0; we_done = 0;
        for (int k = 0; k < 30; k++) begin
            @(negedge clk);
            req_valid = 1'b0;
            bus_dq_in = 16'hA000 + 16'(k);
            if (!bus_cs_n) begin
                cs_cnt++;
                if (bus_addr != a) addr_bad++;
                if (bus_be_n != 2'b01) addr_bad++;
                if (wr && bus_dq_out != 16'hC3A0 + 16'(w)) addr_bad++;
            end
            if (!bus_rd_n || !bus_we_n) seen_strobe = 1;
            if (!bus_cs_n && !seen_strobe) lead++;
            if (!bus_rd_n) rd_cnt++;
            if (!bus_we_n) we_cnt++;
            if (wr && seen_strobe && bus_we_n) we_done = 1;
            if (we_done && !bus_cs_n) post++;
            if (bus_dq_oe) oe_cnt++;
            if (rsp_done) begin done_cnt++; if (done_at < 0) done_at = k; end
        end
        chk(lead, s, {tag, " R3 setup lead"});
        chk(we_cnt, wr ? w + 1 : 0, {tag, " R4 write strobe width"});
        chk(addr_bad, 0, {tag, " R5 addr/be/data stable under cs"});
        if (wr) chk(post, h, {tag, " R5 write hold after strobe"});
        else begin
            chk(rd_cnt, e ? w + 1 : w + 1 + h, {tag, " R7 R8 R9 read strobe width"});
            chk(int'(rsp_rdata), int'(16'hA000 + 16'(s + w)), {tag, " R6 sampled data"});
        end
        chk(cs_cnt, s + w + 1 + h, {tag, " R10 chip select window"});
        chk(done_at, s + w + 1 + h, {tag, " R11 done position"});
        chk(done_cnt, 1, {tag, " R11 done count"});
        chk(oe_cnt, wr ? s + w + 1 + h : 0, {tag, " R12 drive window"});
    endtask

    initial begin
        #100000;
        bad++; total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(req_ready, 1, "R1 ready in reset");
        chk({bus_cs_n, bus_rd_n, bus_we_n}, 3'b111, "R1 strobes idle");
        chk(bus_dq_oe, 0, "R1 no drive");
        chk(rsp_done, 0, "R1 no done");
        chk(int'(cfg_rdata), 0, "R1 register zero");
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready, 1, "R1 ready after reset");

        // R2: implemented-bit mask
        write_cfg(32'hFFFF_FFFF);
        chk(int'(cfg_rdata), int'(32'h077F_77F7), "R2 masked readback");
        write_cfg(32'h8888_8888);
        chk(int'(cfg_rdata), int'(32'h0008_0080), "R2 only areas 1 and 4 keep bit 3");

        foreach (VECS[i]) begin
            run_access(VECS[i].area, VECS[i].kind, VECS[i].wr, VECS[i].wt,
                       VECS[i].cfg, $sformatf("vec%0d", i));
        end

        // R10: unused area number 7 runs with no setup or hold
        run_access(3'd7, 2'd1, 1'b1, 4'd2, 32'h0777_7777, "area7");
        // R4: longest strobe
        run_access(3'd0, 2'd1, 1'b0, 4'd15, 32'h0000_0007, "maxwait");

        // R11: request held while busy is ignored
        write_cfg(32'h0000_0000);
        @(negedge clk);
        area_sram = 7'h01; area_bytectl = '0; strobe_wait = 4'd8;
        req_area = 3'd0; req_addr = 20'h1_2345; req_write = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        chk(req_ready, 0, "R11 not ready while busy");
        req_addr = 20'h0_0BAD;
        begin
            int dn;
            int moved;
            dn = 0;
            moved = 0;
            for (int k = 1; k < 20; k++) begin
                if (k == 4) req_valid = 1'b0;
                if (rsp_done) dn++;
                if (!bus_cs_n && bus_addr != 20'h1_2345) moved++;
                @(negedge clk);
            end
            chk(dn, 1, "R11 single completion under busy request");
            chk(moved, 0, "R11 busy request did not change address");
            chk(bus_cs_n, 1, "R11 no second access started");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule